// File: doc/BRIEF.md
# I2C Master Command Queue Sequencer

This block is the command front end of an I2C master controller. Software queues 11-bit command words into a transmit queue. Each word either carries a byte to send or asks for one byte to be received. It may also ask for a repeated START before the byte and a STOP after it. A sequencer pulls the words one at a time. It turns them into bus operations (START, RESTART, byte write, byte read, STOP) for a downstream bit-level engine, over a valid/ready handshake. The engine answers each accepted operation in the same cycle with an acknowledge/not-acknowledge bit and, for reads, the received byte. Received bytes land in a receive queue that software drains.

The first command after idle, or after a STOP, makes the sequencer send a START and the target address on its own. The direction comes from that command's read flag. Seven-bit and ten-bit target addressing are both supported. When the transmit queue runs dry and no STOP was asked for, the sequencer keeps the bus and waits. A not-acknowledge on any byte the master sends aborts the transfer. The abort empties both queues and ends the transfer with a STOP. Software watches the queue levels, two threshold-based service flags and three sticky error flags.

The controller is a single state machine. Its states are IDLE, START, ADDR_HI (first address byte), ADDR_LO (second ten-bit address byte), ADDR_RS (repeated START inside a ten-bit read header), ADDR_RD (ten-bit read header), HOLD (bus owned, waiting for a command), RESTART, DATA, ABORT and STOP.

Its transitions are:
- IDLE→START when enabled with a command queued.
- START→ADDR_HI on handshake.
- ADDR_HI→ADDR_LO for ten-bit addressing, and ADDR_HI→HOLD for seven-bit addressing.
- ADDR_LO→ADDR_RS for a read, ADDR_LO→HOLD for a write.
- ADDR_RS→ADDR_RD.
- ADDR_RD→HOLD.
- Any address state→ABORT on not-acknowledge.
- HOLD→RESTART when the head command has its restart flag set and not yet served.
- HOLD→DATA otherwise, once a command is queued.
- RESTART→ADDR_HI.
- DATA→STOP when the command's stop flag is set, DATA→ABORT on a not-acknowledged write, and DATA→HOLD otherwise.
- ABORT→STOP.
- STOP→IDLE.

Top module: `i2cm_cmd_sequencer`

## Requirements
- R1: Command word bits: [7:0] are the write byte, bit 8 set means read one byte, bit 9 asks for a STOP after that byte, bit 10 asks for a repeated START before it. Op kinds on `op_kind`: 1 START, 2 RESTART, 3 WRITE, 4 READ, 5 STOP.
- R2: In seven-bit mode (`tar_ten` low), the first command after idle yields START, then WRITE of {tar_addr[6:0], bit 8 of that command}, then the command's own byte operation.
- R3: In ten-bit mode (`tar_ten` high), the header is START, WRITE {11110, tar_addr[9:8], 0}, WRITE tar_addr[7:0]. For a read direction it continues with RESTART and WRITE {11110, tar_addr[9:8], 1}.
- R4: A command with bit 10 set while the bus is owned yields RESTART, then the address phase again with that command's direction, then its byte operation.
- R5: A command with bit 9 set is followed by STOP. The sequencer then goes idle, and the next command starts with a fresh START.
- R6: When the transmit queue is empty and no STOP was requested, `bus_held` is high and no operation is offered until a new command arrives.
- R7: Each read operation pushes `op_rdata` into the receive queue. `rx_rd_data` shows the oldest byte, and `rx_rd_en` removes it.
- R8: `tx_level` and `rx_level` give queue occupancy. `tx_below_thresh` is high when tx_level <= tx_thresh. `rx_above_thresh` is high when rx_level > rx_thresh, so a threshold of 0 flags a single byte.
- R9: A not-acknowledge on any master-sent byte empties both queues, sets the sticky `tx_abort`, and ends the transfer with STOP.
- R10: A command written into a full transmit queue is dropped and sets the sticky `tx_overflow`. Reading an empty receive queue sets the sticky `rx_underflow`. `flag_clr` clears all three sticky flags.
- R11: No READ operation is offered while the receive queue is full. The read goes out once a byte has been removed.
- R12: While `op_valid` is high and `op_ready` is low, `op_valid`, `op_kind` and `op_data` hold steady.
- R13: A transfer begins only while `enable` is high. With `enable` low, queued commands stay in the transmit queue.
- R14: After reset both queues are empty, all sticky flags are low, `bus_held` is low and no operation is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows a new transfer to start |
| tar_ten | input | 1 | Ten-bit target addressing select |
| tar_addr | input | 10 | Target address (low 7 bits used in seven-bit mode) |
| tx_thresh | input | TX_LVL_W | Transmit service threshold |
| rx_thresh | input | RX_LVL_W | Receive service threshold |
| flag_clr | input | 1 | Clears the sticky error flags |
| cmd_wr_en | input | 1 | Pushes a command word |
| cmd_wr_data | input | 11 | Command word |
| rx_rd_en | input | 1 | Removes the oldest received byte |
| rx_rd_data | output | 8 | Oldest received byte |
| tx_level | output | TX_LVL_W | Transmit queue occupancy |
| rx_level | output | RX_LVL_W | Receive queue occupancy |
| tx_below_thresh | output | 1 | Transmit level at or below threshold |
| rx_above_thresh | output | 1 | Receive level above threshold |
| tx_overflow | output | 1 | Sticky: command dropped on full queue |
| rx_underflow | output | 1 | Sticky: read from empty receive queue |
| tx_abort | output | 1 | Sticky: transfer aborted by not-acknowledge |
| bus_held | output | 1 | Bus owned and waiting for commands |
| op_valid | output | 1 | Operation offered to the byte engine |
| op_ready | input | 1 | Byte engine accepts the operation |
| op_kind | output | 3 | Operation kind |
| op_data | output | 8 | Byte to send for WRITE |
| op_nack | input | 1 | Not-acknowledge result of an accepted WRITE |
| op_rdata | input | 8 | Received byte of an accepted READ |

## Verification
The embedded assertions check several properties on every cycle: handshake stability while the engine stalls, the ban on read operations into a full receive queue, and the return to idle after every accepted STOP. They also check that an abort leaves both queues empty one cycle later, and that a write into a full queue leaves its level unchanged. Only the bench scenarios can show that the operation stream has the right order and content. This covers the seven- and ten-bit address headers, a repeated START inserting a new address phase, holding the bus on an empty queue, receive ordering, and the threshold flags at their boundaries.

// File: rtl/i2cm_seq_pkg.sv
package i2cm_seq_pkg;
    localparam int CMD_W        = 11;
    localparam int CMD_RD_BIT   = 8;
    localparam int CMD_STOP_BIT = 9;
    localparam int CMD_RS_BIT   = 10;
    localparam logic [4:0] TEN_PREFIX = 5'b11110;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_START   = 3'd1,
        OP_RESTART = 3'd2,
        OP_WRITE   = 3'd3,
        OP_READ    = 3'd4,
        OP_STOP    = 3'd5
    } op_kind_e;

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_ADDR_HI, S_ADDR_LO, S_ADDR_RS, S_ADDR_RD,
        S_HOLD, S_RESTART, S_DATA, S_ABORT, S_STOP
    } seq_state_e;
endpackage

// File: rtl/i2cm_seq_fifo.sv
module i2cm_seq_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            level <= level + LVL_W'(do_push) - LVL_W'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH)); // R8
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        push && full && !pop && !flush |=> level == $past(level)); // R10
endmodule

// File: rtl/i2cm_seq_fsm.sv
module i2cm_seq_fsm
    import i2cm_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tar_ten,
    input  logic [9:0]       tar_addr,
    input  logic [CMD_W-1:0] cmd_head,
    input  logic             cmd_avail,
    input  logic             rx_full,
    input  logic             op_ready,
    input  logic             op_nack,
    output logic             op_valid,
    output op_kind_e         op_kind,
    output logic [7:0]       op_data,
    output logic             cmd_pop,
    output logic             rx_push,
    output logic             flush,
    output logic             bus_held
);
    seq_state_e state, nxt;
    logic dir, rs_done;
    logic hs, head_rd, want_rs;

    assign hs      = op_valid && op_ready;
    assign head_rd = cmd_head[CMD_RD_BIT];
    assign want_rs = cmd_head[CMD_RS_BIT] && !rs_done;

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (enable && cmd_avail) nxt = S_START;
            S_START:   if (hs) nxt = S_ADDR_HI;
            S_ADDR_HI: if (hs) nxt = op_nack ? S_ABORT : (tar_ten ? S_ADDR_LO : S_HOLD);
            S_ADDR_LO: if (hs) nxt = op_nack ? S_ABORT : (dir ? S_ADDR_RS : S_HOLD);
            S_ADDR_RS: if (hs) nxt = S_ADDR_RD;
            S_ADDR_RD: if (hs) nxt = op_nack ? S_ABORT : S_HOLD;
            S_HOLD:    if (cmd_avail) nxt = want_rs ? S_RESTART : S_DATA;
            S_RESTART: if (hs) nxt = S_ADDR_HI;
            S_DATA:    if (hs) nxt = (op_nack && !head_rd) ? S_ABORT :
                                     (cmd_head[CMD_STOP_BIT] ? S_STOP : S_HOLD);
            S_ABORT:   nxt = S_STOP;
            S_STOP:    if (hs) nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            dir     <= 1'b0;
            rs_done <= 1'b0;
        end else begin
            state <= nxt;
            if ((state == S_IDLE && nxt == S_START) || (state == S_HOLD && nxt == S_RESTART))
                dir <= head_rd;
            if (cmd_pop || state == S_ABORT)
                rs_done <= 1'b0;
            else if (state == S_RESTART && hs)
                rs_done <= 1'b1;
        end
    end

    always_comb begin
        op_valid = 1'b0;
        op_kind  = OP_NONE;
        op_data  = '0;
        unique case (state)
            S_START: begin
                op_valid = 1'b1;
                op_kind  = OP_START;
            end
            S_ADDR_HI: begin
                op_valid = 1'b1;
                op_kind  = OP_WRITE;
                op_data  = tar_ten ? {TEN_PREFIX, tar_addr[9:8], 1'b0} : {tar_addr[6:0], dir};
            end
            S_ADDR_LO: begin
                op_valid = 1'b1;
                op_kind  = OP_WRITE;
                op_data  = tar_addr[7:0];
            end
            S_ADDR_RS, S_RESTART: begin
                op_valid = 1'b1;
                op_kind  = OP_RESTART;
            end
            S_ADDR_RD: begin
                op_valid = 1'b1;
                op_kind  = OP_WRITE;
                op_data  = {TEN_PREFIX, tar_addr[9:8], 1'b1};
            end
            S_DATA: begin
                op_valid = !(head_rd && rx_full);
                op_kind  = head_rd ? OP_READ : OP_WRITE;
                op_data  = head_rd ? 8'h00 : cmd_head[7:0];
            end
            S_STOP: begin
                op_valid = 1'b1;
                op_kind  = OP_STOP;
            end
            default: ;
        endcase
    end

    assign cmd_pop  = (state == S_DATA) && hs;
    assign rx_push  = cmd_pop && head_rd;
    assign flush    = (state == S_ABORT);
    assign bus_held = (state == S_HOLD);

    AST_VALID_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !op_ready |=> op_valid && $stable(op_kind) && $stable(op_data)); // R12
    AST_READ_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_kind == OP_READ |-> !rx_full); // R11
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_ready && op_kind == OP_STOP |=> !op_valid && !bus_held); // R5
endmodule

// File: rtl/i2cm_cmd_sequencer.sv
module i2cm_cmd_sequencer
    import i2cm_seq_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8,
    localparam int TX_LVL_W = $clog2(TX_DEPTH + 1),
    localparam int RX_LVL_W = $clog2(RX_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                tar_ten,
    input  logic [9:0]          tar_addr,
    input  logic [TX_LVL_W-1:0] tx_thresh,
    input  logic [RX_LVL_W-1:0] rx_thresh,
    input  logic                flag_clr,
    input  logic                cmd_wr_en,
    input  logic [CMD_W-1:0]    cmd_wr_data,
    input  logic                rx_rd_en,
    output logic [7:0]          rx_rd_data,
    output logic [TX_LVL_W-1:0] tx_level,
    output logic [RX_LVL_W-1:0] rx_level,
    output logic                tx_below_thresh,
    output logic                rx_above_thresh,
    output logic                tx_overflow,
    output logic                rx_underflow,
    output logic                tx_abort,
    output logic                bus_held,
    output logic                op_valid,
    input  logic                op_ready,
    output logic [2:0]          op_kind,
    output logic [7:0]          op_data,
    input  logic                op_nack,
    input  logic [7:0]          op_rdata
);
    logic [CMD_W-1:0] cmd_head;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic cmd_pop, rx_push, flush;
    op_kind_e kind;

    i2cm_seq_fifo #(.WIDTH(CMD_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(cmd_wr_en), .push_data(cmd_wr_data),
        .pop(cmd_pop), .head(cmd_head), .level(tx_level),
        .full(tx_full), .empty(tx_empty)
    );

    i2cm_seq_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(rx_push), .push_data(op_rdata),
        .pop(rx_rd_en), .head(rx_rd_data), .level(rx_level),
        .full(rx_full), .empty(rx_empty)
    );

    i2cm_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .tar_ten(tar_ten), .tar_addr(tar_addr),
        .cmd_head(cmd_head), .cmd_avail(!tx_empty), .rx_full(rx_full),
        .op_ready(op_ready), .op_nack(op_nack),
        .op_valid(op_valid), .op_kind(kind), .op_data(op_data),
        .cmd_pop(cmd_pop), .rx_push(rx_push), .flush(flush),
        .bus_held(bus_held)
    );

    assign op_kind         = kind;
    assign tx_below_thresh = (tx_level <= tx_thresh);
    assign rx_above_thresh = (rx_level > rx_thresh);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_overflow  <= 1'b0;
            rx_underflow <= 1'b0;
            tx_abort     <= 1'b0;
        end else begin
            tx_overflow  <= (tx_overflow && !flag_clr) || (cmd_wr_en && tx_full);
            rx_underflow <= (rx_underflow && !flag_clr) || (rx_rd_en && rx_empty);
            tx_abort     <= (tx_abort && !flag_clr) || flush;
        end
    end

    AST_ABORT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (tx_level == '0) && (rx_level == '0) && tx_abort); // R9
endmodule

// File: tb/i2cm_cmd_sequencer_test.sv
`timescale 1ns/1ps
module i2cm_cmd_sequencer_test;
    import i2cm_seq_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, tar_ten = 1'b0, flag_clr = 1'b0;
    logic [9:0] tar_addr = '0;
    logic [3:0] tx_thresh = '0, rx_thresh = '0;
    logic cmd_wr_en = 1'b0, rx_rd_en = 1'b0;
    logic [10:0] cmd_wr_data = '0;
    logic [7:0] rx_rd_data, op_data, op_rdata;
    logic [3:0] tx_level, rx_level;
    logic tx_below_thresh, rx_above_thresh, tx_overflow, rx_underflow, tx_abort, bus_held;
    logic op_valid, op_nack;
    logic op_ready = 1'b1;
    logic [2:0] op_kind;

    logic nack_en = 1'b0;
    logic [7:0] nack_byte = '0;
    logic [7:0] rd_cnt = '0;
    int log_kind [64];
    int log_data [64];
    int n_ops = 0;
    int tests = 0, fails = 0;

    always #4 clk = ~clk;

    i2cm_cmd_sequencer uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tar_ten(tar_ten), .tar_addr(tar_addr),
        .tx_thresh(tx_thresh), .rx_thresh(rx_thresh), .flag_clr(flag_clr),
        .cmd_wr_en(cmd_wr_en), .cmd_wr_data(cmd_wr_data), .rx_rd_en(rx_rd_en),
        .rx_rd_data(rx_rd_data), .tx_level(tx_level), .rx_level(rx_level),
        .tx_below_thresh(tx_below_thresh), .rx_above_thresh(rx_above_thresh),
        .tx_overflow(tx_overflow), .rx_underflow(rx_underflow), .tx_abort(tx_abort),
        .bus_held(bus_held), .op_valid(op_valid), .op_ready(op_ready), .op_kind(op_kind),
        .op_data(op_data), .op_nack(op_nack), .op_rdata(op_rdata)
    );

    // byte engine model
    assign op_nack  = nack_en && (op_kind == OP_WRITE) && (op_data == nack_byte);
    assign op_rdata = 8'hC0 + rd_cnt;
    always @(posedge clk) if (op_valid && op_ready && op_kind == OP_READ) rd_cnt <= rd_cnt + 8'd1;
    always @(negedge clk) begin
        if (op_valid && op_ready && n_ops < 64) begin
            log_kind[n_ops] = int'(op_kind);
            log_data[n_ops] = int'(op_data);
            n_ops = n_ops + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic op_is(input int idx, input op_kind_e k, input int d, input string req);
        bit ok;
        ok = (log_kind[idx] == int'(k)) && (k != OP_WRITE || log_data[idx] == d);
        check(ok, req, (log_kind[idx] << 8) | log_data[idx], (int'(k) << 8) | d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; enable = 1'b0; nack_en = 1'b0; op_ready = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        n_ops = 0;
    endtask

    task automatic push(input logic [10:0] w);
        @(negedge clk);
        cmd_wr_en = 1'b1; cmd_wr_data = w;
        @(negedge clk);
        cmd_wr_en = 1'b0;
    endtask

    task automatic pop_rx();
        @(negedge clk); rx_rd_en = 1'b1;
        @(negedge clk); rx_rd_en = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic run_txn();
        @(negedge clk); n_ops = 0; enable = 1'b1;
        repeat (60) @(negedge clk);
        enable = 1'b0;
    endtask

    // {tx_thresh, words pushed, expected tx_below_thresh}
    localparam logic [11:0] TBL [6] = '{12'h001, 12'h010, 12'h331, 12'h340, 12'h780, 12'h881};

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] base;
        // R14 reset state
        do_reset();
        check(tx_level == 0 && rx_level == 0, "R14 levels", tx_level, 0);
        check(!op_valid && !bus_held, "R14 idle", op_valid, 0);
        check(!tx_overflow && !rx_underflow && !tx_abort, "R14 flags", tx_abort, 0);

        // table: R8 thresholds, R13 enable gating
        for (int i = 0; i < 6; i++) begin
            do_reset();
            tx_thresh = TBL[i][11:8];
            for (int j = 0; j < int'(TBL[i][7:4]); j++) push(11'h010 + 11'(j));
            repeat (3) @(negedge clk);
            check(tx_level == TBL[i][7:4], "R8 tx level", tx_level, TBL[i][7:4]);
            check(tx_below_thresh == TBL[i][0], "R8 tx below thresh", tx_below_thresh, TBL[i][0]);
            check(!op_valid && n_ops == 0, "R13 no start while disabled", n_ops, 0);
        end
        tx_thresh = '0;

        // R2 R1 R5 seven-bit write with stop, R12 stall
        do_reset();
        tar_addr = 10'h02A; op_ready = 1'b0;
        push(11'h055); push(11'h266);
        @(negedge clk); enable = 1'b1;
        repeat (5) @(negedge clk);
        check(op_valid && op_kind == OP_START && n_ops == 0, "R12 stable under stall", op_kind, 1);
        op_ready = 1'b1;
        repeat (40) @(negedge clk);
        enable = 1'b0;
        check(n_ops == 5, "R2 op count", n_ops, 5);
        op_is(0, OP_START, 0, "R2 start");
        op_is(1, OP_WRITE, 8'h54, "R2 address byte");
        op_is(2, OP_WRITE, 8'h55, "R1 data byte");
        op_is(3, OP_WRITE, 8'h66, "R1 data byte with stop");
        op_is(4, OP_STOP, 0, "R5 stop after flagged byte");
        check(!op_valid && !bus_held && tx_level == 0, "R5 idle after stop", op_valid, 0);

        // R6 hold bus on empty queue
        push(11'h0AB);
        run_txn();
        check(n_ops == 3 && bus_held && !op_valid, "R6 held", n_ops, 3);
        op_is(0, OP_START, 0, "R5 fresh start");
        op_is(2, OP_WRITE, 8'hAB, "R6 byte before hold");
        push(11'h2CD);
        repeat (20) @(negedge clk);
        check(n_ops == 5 && !bus_held, "R6 resume", n_ops, 5);
        op_is(3, OP_WRITE, 8'hCD, "R6 resumed byte");
        op_is(4, OP_STOP, 0, "R6 stop");

        // R4 repeated start with direction change
        push(11'h011); push(11'h700);
        run_txn();
        check(n_ops == 7, "R4 op count", n_ops, 7);
        op_is(1, OP_WRITE, 8'h54, "R4 write address");
        op_is(2, OP_WRITE, 8'h11, "R4 byte");
        op_is(3, OP_RESTART, 0, "R4 restart");
        op_is(4, OP_WRITE, 8'h55, "R4 read address");
        op_is(5, OP_READ, 0, "R4 read");
        op_is(6, OP_STOP, 0, "R4 stop");
        pop_rx();

        // R7 R8 receive ordering and threshold, R10 underflow
        tar_addr = 10'h050; rx_thresh = '0;
        base = rd_cnt;
        push(11'h100); push(11'h300);
        run_txn();
        check(n_ops == 5, "R7 op count", n_ops, 5);
        op_is(1, OP_WRITE, 8'hA1, "R2 read direction bit");
        check(rx_level == 2 && rx_above_thresh, "R8 rx level above thresh", rx_level, 2);
        rx_thresh = 4'd2;
        @(negedge clk);
        check(!rx_above_thresh, "R8 rx at thresh not flagged", rx_above_thresh, 0);
        check(rx_rd_data == 8'(base + 8'hC0), "R7 oldest byte", rx_rd_data, base + 8'hC0);
        pop_rx();
        check(rx_rd_data == 8'(base + 8'hC1), "R7 second byte", rx_rd_data, base + 8'hC1);
        pop_rx();
        check(rx_level == 0 && !rx_underflow, "R7 drained", rx_level, 0);
        pop_rx();
        @(negedge clk);
        check(rx_underflow, "R10 underflow sticky", rx_underflow, 1);
        clear_flags();
        check(!rx_underflow, "R10 flag clear", rx_underflow, 0);

        // R3 ten-bit write and read
        tar_ten = 1'b1; tar_addr = 10'h2B5;
        push(11'h233);
        run_txn();
        check(n_ops == 5, "R3 write op count", n_ops, 5);
        op_is(1, OP_WRITE, 8'hF4, "R3 header");
        op_is(2, OP_WRITE, 8'hB5, "R3 low address");
        op_is(3, OP_WRITE, 8'h33, "R3 data");
        push(11'h300);
        run_txn();
        check(n_ops == 7, "R3 read op count", n_ops, 7);
        op_is(3, OP_RESTART, 0, "R3 header restart");
        op_is(4, OP_WRITE, 8'hF5, "R3 read header");
        op_is(5, OP_READ, 0, "R3 read");
        check(rx_level == 1, "R7 ten-bit read stored", rx_level, 1);
        tar_ten = 1'b0;

        // R9 abort on address nack flushes both queues
        tar_addr = 10'h033; nack_en = 1'b1; nack_byte = 8'h66;
        push(11'h011); push(11'h022); push(11'h233);
        run_txn();
        check(n_ops == 3, "R9 op count", n_ops, 3);
        op_is(1, OP_WRITE, 8'h66, "R9 nacked address");
        op_is(2, OP_STOP, 0, "R9 stop after abort");
        check(tx_level == 0 && rx_level == 0, "R9 queues flushed", {tx_level, rx_level}, 0);
        check(tx_abort, "R9 abort flag", tx_abort, 0);
        nack_en = 1'b0;
        clear_flags();

        // R11 read stalls on full receive queue
        tar_addr = 10'h050;
        push(11'h300);
        run_txn();
        for (int j = 0; j < 7; j++) push(11'h100);
        push(11'h300);
        run_txn();
        check(rx_level == 8 && !op_valid && tx_level == 1, "R11 stalled", rx_level, 8);
        check(n_ops == 9, "R11 ops before stall", n_ops, 9);
        pop_rx();
        repeat (20) @(negedge clk);
        check(n_ops == 11 && rx_level == 8, "R11 resumed", n_ops, 11);
        op_is(9, OP_READ, 0, "R11 deferred read");
        op_is(10, OP_STOP, 0, "R11 stop");

        // R10 overflow drops the word
        do_reset();
        for (int j = 0; j < 8; j++) push(11'h000 + 11'(j));
        push(11'h2EE);
        @(negedge clk);
        check(tx_level == 8 && tx_overflow, "R10 overflow", tx_level, 8);
        run_txn();
        check(n_ops == 10 && bus_held, "R10 dropped stop word", n_ops, 10);
        op_is(9, OP_WRITE, 8'h07, "R10 last kept word");
        clear_flags();
        check(!tx_overflow, "R10 clear", tx_overflow, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule